// File: doc/BRIEF.md
# Thermometer-to-Gray Flash Decoder

This block turns the comparator bank of an 8-bit flash converter into a sample word. The bank arrives as a 256-bit thermometer vector. Bit k is set when the analog input lies above threshold k, and bit 0 is the lowest threshold. Bits 0 to 254 are the ordinary comparators. Bit 255 sits above full scale and serves as the overrange detector. The output is an 8-bit Gray code plus a separate overrange flag.

The vector is captured on the falling clock edge. A three-input majority vote then removes isolated bubbles. The cleaned vector is split into four 64-wide columns. Each column has its own 64-to-6 fine encoder, and a column encoder picks the column that holds the transition. The column index and the fine code of the chosen column form the 8-bit binary value, which is converted to Gray and registered on the next falling edge. Column count and fine width are parameters, so other resolutions can be built.

Top module: `therm_gray_decoder`

## Requirements
- R1: The binary sample value is the number of set bits among comparators 0..254 after bubble correction; for a clean thermometer vector with the lowest L bits set (L ≤ 255) the value is L.
- R2: Values on either side of each 64-wide column boundary (63/64, 127/128, 191/192) decode to their exact codes.
- R3: An all-zero comparator vector gives `gray_out` = 00000000 with `ovr_out` low.
- R4: With comparators 0..254 set and 255 clear, `gray_out` = 10000000. A value of 128 gives 11000000 and a value of 127 gives 01000000.
- R5: When comparator 255 survives bubble correction, `ovr_out` is high and `gray_out` holds 10000000.
- R6: `therm_in` is sampled on a falling clock edge. The result appears on the outputs at the next falling edge and holds until the falling edge after that.
- R7: Before decoding, each bit is replaced by the majority of itself and its two neighbours. The missing neighbour below bit 0 counts as 1, and the missing neighbour above bit 255 counts as 0. A single flipped bit in an otherwise clean thermometer vector therefore moves the result by at most 1 LSB (overrange counted as value 256).
- R8: A synchronous active-high `rst`, sampled on the falling edge, clears the capture and output registers. The outputs then read 00000000 with `ovr_out` low.
- R9: `gray_out` equals b XOR (b >> 1), where b is the 8-bit binary value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers act on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| therm_in | input | 256 | Comparator vector, bit 0 = lowest threshold, bit 255 = overrange comparator |
| gray_out | output | 8 | Registered Gray-coded sample |
| ovr_out | output | 1 | Registered overrange flag |

## Verification
Each result is due at the second falling edge after the vector is applied: one edge captures the vector and the next loads the output register. The bench changes the input just after a rising edge. It samples one rising edge later, when the output must still show the previous result. It samples again one rising edge after that, when the new result must be present. Reset clearing is checked at the first rising edge after the falling edge that saw `rst` high. The checker properties look back exactly two falling edges, which is where the captured input lies.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
    // default geometry: 4 columns of 64 comparators -> 8-bit code
    localparam int unsigned TG_COL_BITS_DEF  = 2;
    localparam int unsigned TG_FINE_BITS_DEF = 6;

    // reflected binary conversion on a wide word; callers slice the result
    function automatic logic [31:0] tg_to_gray(input logic [31:0] bin);
        return bin ^ (bin >> 1);
    endfunction
endpackage

// File: rtl/tg_bubble_filter.sv
`timescale 1ns/1ps
module tg_bubble_filter #(
    parameter int unsigned WIDTH = 256
) (
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] clean_o
);
    // each bit becomes the 2-of-3 vote of itself and its neighbours;
    // virtual neighbour below bit 0 is 1, above the top bit is 0
    for (genvar i = 0; i < WIDTH; i++) begin : g_vote
        logic below;
        logic above;
        if (i == 0) begin : g_lo_edge
            assign below = 1'b1;
        end else begin : g_lo_mid
            assign below = raw_i[i-1];
        end
        if (i == WIDTH-1) begin : g_hi_edge
            assign above = 1'b0;
        end else begin : g_hi_mid
            assign above = raw_i[i+1];
        end
        assign clean_o[i] = (below & raw_i[i]) | (below & above) | (raw_i[i] & above);
    end
endmodule

// File: rtl/tg_prio_encoder.sv
`timescale 1ns/1ps
module tg_prio_encoder #(
    parameter int unsigned IN_W  = 64,
    parameter int unsigned OUT_W = 6
) (
    input  logic [IN_W-1:0]  therm_i,
    output logic [OUT_W-1:0] code_o
);
    // index of the highest set input; zero when none is set
    always_comb begin
        code_o = '0;
        for (int i = 0; i < IN_W; i++) begin
            if (therm_i[i]) begin
                code_o = OUT_W'(i);
            end
        end
    end
endmodule

// File: rtl/therm_gray_decoder.sv
`timescale 1ns/1ps
module therm_gray_decoder #(
    parameter int unsigned COL_BITS  = tg_pkg::TG_COL_BITS_DEF,
    parameter int unsigned FINE_BITS = tg_pkg::TG_FINE_BITS_DEF
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [(1<<(COL_BITS+FINE_BITS))-1:0]   therm_in,
    output logic [COL_BITS+FINE_BITS-1:0]          gray_out,
    output logic                                   ovr_out
);
    localparam int unsigned CODE_W   = COL_BITS + FINE_BITS;
    localparam int unsigned NUM_COMP = 1 << CODE_W;
    localparam int unsigned NUM_COL  = 1 << COL_BITS;
    localparam int unsigned COL_W    = 1 << FINE_BITS;

    // capture stage on the falling edge
    logic [NUM_COMP-1:0] cap_q;
    always_ff @(negedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= therm_in;
    end

    logic [NUM_COMP-1:0] clean;
    tg_bubble_filter #(.WIDTH(NUM_COMP)) u_filter (
        .raw_i  (cap_q),
        .clean_o(clean)
    );

    // shift up by one with a constant 1 at the bottom: position m of the
    // shifted vector stands for "value is at least m", so each column sees
    // exactly COL_W positions and the column base bit tells if it is reached
    logic [NUM_COMP-1:0] reach;
    assign reach = {clean[NUM_COMP-2:0], 1'b1};

    logic [FINE_BITS-1:0] fine_code [NUM_COL];
    logic [NUM_COL-1:0]   col_hit;

    for (genvar c = 0; c < NUM_COL; c++) begin : g_col
        tg_prio_encoder #(.IN_W(COL_W), .OUT_W(FINE_BITS)) u_fine (
            .therm_i(reach[c*COL_W +: COL_W]),
            .code_o (fine_code[c])
        );
        assign col_hit[c] = reach[c*COL_W];
    end

    logic [COL_BITS-1:0] col_idx;
    tg_prio_encoder #(.IN_W(NUM_COL), .OUT_W(COL_BITS)) u_col (
        .therm_i(col_hit),
        .code_o (col_idx)
    );

    logic              over;
    logic [CODE_W-1:0] bin_val;
    logic [CODE_W-1:0] gray_nxt;
    logic [31:0]       gray_wide;

    assign over      = clean[NUM_COMP-1];
    assign bin_val   = over ? {CODE_W{1'b1}} : {col_idx, fine_code[col_idx]};
    assign gray_wide = tg_pkg::tg_to_gray(32'(bin_val));
    assign gray_nxt  = gray_wide[CODE_W-1:0];

    // output stage, one falling edge after capture
    always_ff @(negedge clk) begin
        if (rst) begin
            gray_out <= '0;
            ovr_out  <= 1'b0;
        end else begin
            gray_out <= gray_nxt;
            ovr_out  <= over;
        end
    end
endmodule

// File: rtl/tg_decoder_checker.sv
`timescale 1ns/1ps
module tg_decoder_checker #(
    parameter int unsigned CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [(1<<CODE_W)-1:0]   therm_in,
    input logic [CODE_W-1:0]        gray_out,
    input logic                     ovr_out
);
    localparam int unsigned N = 1 << CODE_W;
    localparam logic [CODE_W-1:0] FULL_GRAY = {1'b1, {(CODE_W-1){1'b0}}};

    // R5: overrange always carries the full-scale code
    p_ovr_code_r5: assert property (@(posedge clk) disable iff (rst)
        ovr_out |-> gray_out == FULL_GRAY);

    // R5 / R7: overrange needs the top two comparators set in the captured vector
    p_ovr_source_r5: assert property (@(negedge clk) disable iff (rst)
        ovr_out |-> ($past(therm_in[N-1], 2) && $past(therm_in[N-2], 2)));

    // R3 / R6: an empty vector two falling edges back yields code zero
    p_zero_r3: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && ($past(therm_in, 2) == '0))
        |-> (gray_out == '0 && !ovr_out));

    // R4 / R6: all ordinary comparators set, top clear -> full-scale code
    p_full_r4: assert property (@(negedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) &&
         $past((&therm_in[N-2:0]) && !therm_in[N-1], 2))
        |-> (gray_out == FULL_GRAY && !ovr_out));

    // R8: right after reset is released the outputs are still cleared
    p_reset_clear_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (gray_out == '0 && !ovr_out));
endmodule

bind therm_gray_decoder tg_decoder_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .therm_in(therm_in),
    .gray_out(gray_out),
    .ovr_out (ovr_out)
);

// File: tb/therm_gray_decoder_bench.sv
`timescale 1ns/1ps
module therm_gray_decoder_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [255:0] therm_in = '0;
    logic [7:0]   gray_out;
    logic         ovr_out;

    int vec_cnt  = 0;
    int miss_cnt = 0;
    logic [7:0] prev_g = 8'h00;
    logic       prev_o = 1'b0;

    always #2.5 clk = ~clk;

    therm_gray_decoder u_therm_gray_decoder (
        .clk     (clk),
        .rst     (rst),
        .therm_in(therm_in),
        .gray_out(gray_out),
        .ovr_out (ovr_out)
    );

    function automatic logic [255:0] therm_of(input int lvl);
        logic [255:0] v = '0;
        for (int k = 0; k < 256; k++) if (k < lvl) v[k] = 1'b1;
        return v;
    endfunction

    // value after the majority vote: 0..255, or 256 for overrange
    function automatic int model_val(input logic [255:0] v);
        logic [255:0] c;
        for (int k = 0; k < 256; k++) begin
            logic lo, hi;
            lo = (k == 0)   ? 1'b1 : v[k-1];
            hi = (k == 255) ? 1'b0 : v[k+1];
            c[k] = (lo & v[k]) | (lo & hi) | (v[k] & hi);
        end
        if (c[255]) return 256;
        for (int k = 254; k >= 0; k--) if (c[k]) return k + 1;
        return 0;
    endfunction

    function automatic logic [7:0] gray_of(input int val);
        logic [7:0] b;
        b = (val >= 255) ? 8'hFF : 8'(val);
        return b ^ (b >> 1);
    endfunction

    function automatic int val_of_gray(input logic [7:0] g, input logic o);
        logic [7:0] b;
        if (o) return 256;
        b[7] = g[7];
        for (int k = 6; k >= 0; k--) b[k] = b[k+1] ^ g[k];
        return int'(b);
    endfunction

    task automatic check(input string req, input logic [7:0] eg, input logic eo);
        vec_cnt++;
        if (gray_out !== eg || ovr_out !== eo) begin
            miss_cnt++;
            $display("FAIL %s: gray=%b ovr=%b, expected gray=%b ovr=%b",
                     req, gray_out, ovr_out, eg, eo);
        end
    endtask

    task automatic apply(input logic [255:0] v, input string req, input int lvl);
        int ev;
        @(posedge clk);
        therm_in = v;
        @(posedge clk);
        #1;
        check("R6 latency (old result held)", prev_g, prev_o);
        @(posedge clk);
        #1;
        ev = model_val(v);
        check(req, gray_of(ev), ev == 256);
        if (lvl >= 0) begin
            int got, d;
            got = val_of_gray(gray_out, ovr_out);
            d = got - lvl;
            vec_cnt++;
            if (d > 1 || d < -1) begin
                miss_cnt++;
                $display("FAIL R7 tolerance: value %0d, expected %0d +/-1", got, lvl);
            end
        end
        prev_g = gray_of(ev);
        prev_o = (ev == 256);
    endtask

    initial begin
        #(5.0 * 200000);
        miss_cnt++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R8 reset state", 8'h00, 1'b0);

        apply(therm_of(0),   "R3 empty vector", 0);
        apply(therm_of(255), "R4 full scale", 255);
        apply(therm_of(128), "R4 just above mid", 128);
        apply(therm_of(127), "R4 just below mid", 127);
        apply(therm_of(63),  "R2 boundary 63", 63);
        apply(therm_of(64),  "R2 boundary 64", 64);
        apply(therm_of(191), "R2 boundary 191", 191);
        apply(therm_of(192), "R2 boundary 192", 192);
        apply(therm_of(1),   "R1 single comparator", 1);
        apply(therm_of(256), "R5 overrange", 256);
        apply(therm_of(256) & ~(256'(1) << 254), "R7 hole under top", 256);
        apply(therm_of(10) | (256'(1) << 255), "R7 stray top bit", 10);
        apply(therm_of(100) & ~(256'(1) << 50), "R7 deep hole", 100);
        apply(therm_of(100) | (256'(1) << 200), "R7 stray high bit", 100);
        apply(therm_of(0) | 256'(1), "R7 bit0 alone", 0);

        // mid-run reset
        @(posedge clk);
        therm_in = therm_of(200);
        repeat (2) @(posedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R8 reset clears", 8'h00, 1'b0);
        @(posedge clk);
        rst = 1'b0;
        prev_g = 8'h00;
        prev_o = 1'b0;
        @(posedge clk);
        #1;
        check("R8 cleared after release", 8'h00, 1'b0);
        // capture register still holds the 200 vector now
        prev_g = gray_of(200);

        for (int n = 0; n < 300; n++) begin
            int lvl;
            logic [255:0] v;
            lvl = int'($urandom_range(0, 256));
            v = therm_of(lvl);
            if ($urandom_range(0, 1) == 1) begin
                int p;
                p = int'($urandom_range(0, 255));
                v[p] = ~v[p];
                apply(v, "R7 R1 R9 random single flip", lvl);
            end else begin
                apply(v, "R1 R9 random clean level", lvl);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, miss_cnt);
        $finish;
    end
endmodule